// File: doc/BRIEF.md
# Debug link instruction sequencer

This block watches the byte stream of a two-way debug and programming link and works out, byte by byte, what each byte means. The first byte after reset, after a break, or after the end of an instruction is an instruction byte; its top three bits select the operation and its low four bits size the operands. From that byte the sequencer builds an operand schedule: how many items follow, how wide each one is, and whether each travels from the host to the device or back. Later bytes are collected, least significant byte first, into items of one to four bytes. Each completed item is presented with its width and direction.

A repeat instruction stores a count N. The next pointer-based load or store then moves N+1 items instead of one, and uses up the count. A break abandons whatever instruction is in progress, drops any pending count, and makes the next byte an instruction byte again. The block only observes the stream. It keeps no memory image and does not interpret key contents or addresses.

Top module: `dbg_insn_seq`

## Requirements
- R1: A byte accepted while no instruction is open raises `op_vld` for one cycle, in the cycle after the byte, with `op_code` equal to bits 7:5 of the byte. The encodings are 0 load-direct, 1 load-pointer, 2 store-direct, 3 store-pointer, 4 load-control, 5 repeat, 6 store-control, 7 key. A byte that opens an instruction never produces an item.
- R2: Load-direct first moves an address item from host to device (`item_dir`=0), (bits 3:2)+1 bytes wide. It then moves one data item from device to host (`item_dir`=1), (bits 1:0)+1 bytes wide.
- R3: Store-direct moves an address item of (bits 3:2)+1 bytes and then a data item of (bits 1:0)+1 bytes. Both items go host to device.
- R4: Item bytes arrive least significant first. The first byte lands in `item_data[7:0]` and bits above the item width read zero. `item_bytes` gives the width, 1 to 4. `item_vld` pulses in the cycle after the item's last byte.
- R5: Load-control and store-control each move exactly one 1-byte item, device to host and host to device respectively, whatever bits 3:0 hold.
- R6: Key moves eight 1-byte host-to-device items, and the command ends with the eighth.
- R7: Repeat moves one host-to-device item of (bits 1:0)+1 bytes. When that item completes, `rep_vld` pulses and `rep_count` shows its value.
- R8: After repeat N, the next load-pointer or store-pointer moves N+1 items of (bits 1:0)+1 bytes, whatever pointer mode bits 3:2 select. That instruction uses up the count, so the pointer instruction after it moves one item again.
- R9: Direct, control and key instructions that come between a repeat and a pointer instruction leave the pending count untouched.
- R10: `brk` ends any open instruction, clears the pending repeat count, and makes the next byte an instruction byte. A byte presented together with `brk` is ignored.
- R11: `cmd_done` pulses together with the `item_vld` of an instruction's last item, and at no other time.
- R12: `rep_ovf` pulses with `rep_vld` when a repeat value N makes N+1 exceed the item counter's range, that is, when N is 2^CNT_W-1 or more. With the default CNT_W of 32 this is the value 0xFFFFFFFF.
- R13: During and right after reset, every strobe output is low and `rep_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_vld | input | 1 | A byte is present on `byte_data` this cycle |
| byte_data | input | 8 | Link byte |
| brk | input | 1 | Break seen on the link this cycle |
| op_vld | output | 1 | Instruction byte decoded |
| op_code | output | 3 | Operation of the last instruction byte |
| item_vld | output | 1 | An item completed |
| item_data | output | 32 | Assembled item, zero-extended |
| item_bytes | output | 3 | Item width in bytes, 1 to 4 |
| item_dir | output | 1 | 0 host to device, 1 device to host |
| cmd_done | output | 1 | The instruction's last item completed |
| rep_vld | output | 1 | A repeat count was captured |
| rep_count | output | 32 | Last captured repeat value |
| rep_ovf | output | 1 | The captured repeat value is out of range |

## Verification
Two pairs of events can land in the same cycle. The first is a break and a byte: the bench raises `brk` with a byte on the same edge, then checks that no opcode or item strobe follows and that the next byte decodes as an instruction. The second is the last item of an instruction, its end of command, and for repeat the count capture. The bench expects `item_vld`, `cmd_done` and `rep_vld` in one cycle with the final byte, and checks that `cmd_done` stays low on every earlier item of a multi-item instruction.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  localparam int ITEM_MAX_BYTES = 4;
  localparam int ITEM_W         = 8 * ITEM_MAX_BYTES;
  localparam int WID_W          = $clog2(ITEM_MAX_BYTES + 1);
  localparam int KEY_ITEMS      = 8;

  typedef enum logic [2:0] {
    OPC_LD_DIR = 3'd0,
    OPC_LD_PTR = 3'd1,
    OPC_ST_DIR = 3'd2,
    OPC_ST_PTR = 3'd3,
    OPC_LD_CTL = 3'd4,
    OPC_REPEAT = 3'd5,
    OPC_ST_CTL = 3'd6,
    OPC_KEY    = 3'd7
  } opc_e;

  typedef enum logic {
    DIR_H2D = 1'b0,
    DIR_D2H = 1'b1
  } dir_e;

  // Operand schedule: up to two segments, the first may hold many items.
  typedef struct packed {
    opc_e             opc;
    dir_e             dir0;
    logic [WID_W-1:0] wid0;
    logic             seg2;
    dir_e             dir1;
    logic [WID_W-1:0] wid1;
    logic             rep_use;
    logic             key_run;
  } sched_t;

endpackage

// File: rtl/dbg_seq_decode.sv
module dbg_seq_decode
  import dbg_seq_pkg::*;
(
  input  logic [2:0] opc_bits,
  input  logic [3:0] arg_bits,
  output sched_t     sched
);

  logic [WID_W-1:0] wid_hi;
  logic [WID_W-1:0] wid_lo;

  assign wid_hi = WID_W'(arg_bits[3:2]) + WID_W'(1);
  assign wid_lo = WID_W'(arg_bits[1:0]) + WID_W'(1);

  always_comb begin
    sched         = '0;
    sched.opc     = opc_e'(opc_bits);
    sched.dir0    = DIR_H2D;
    sched.dir1    = DIR_H2D;
    sched.wid0    = WID_W'(1);
    sched.wid1    = WID_W'(1);
    unique case (opc_e'(opc_bits))
      OPC_LD_DIR: begin
        sched.wid0 = wid_hi;
        sched.seg2 = 1'b1;
        sched.dir1 = DIR_D2H;
        sched.wid1 = wid_lo;
      end
      OPC_ST_DIR: begin
        sched.wid0 = wid_hi;
        sched.seg2 = 1'b1;
        sched.wid1 = wid_lo;
      end
      OPC_LD_PTR: begin
        sched.dir0    = DIR_D2H;
        sched.wid0    = wid_lo;
        sched.rep_use = 1'b1;
      end
      OPC_ST_PTR: begin
        sched.wid0    = wid_lo;
        sched.rep_use = 1'b1;
      end
      OPC_LD_CTL: sched.dir0 = DIR_D2H;
      OPC_ST_CTL: sched.dir0 = DIR_H2D;
      OPC_REPEAT: sched.wid0 = wid_lo;
      OPC_KEY:    sched.key_run = 1'b1;
      default:    sched.wid0 = WID_W'(1);
    endcase
  end

endmodule

// File: rtl/dbg_seq_asm.sv
module dbg_seq_asm
  import dbg_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [7:0]        din,
  input  logic [WID_W-1:0]  wid,
  output logic              last,
  output logic [ITEM_W-1:0] value
);

  localparam int IDX_W = $clog2(ITEM_MAX_BYTES);

  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [ITEM_W-1:0] acc_q, acc_n;
  logic [ITEM_W-1:0] shifted;

  assign last    = (WID_W'(idx_q) + WID_W'(1)) == wid;
  assign shifted = ITEM_W'(din) << {idx_q, 3'b000};
  assign value   = ((idx_q == '0) ? '0 : acc_q) | shifted;

  always_comb begin
    idx_n = idx_q;
    acc_n = acc_q;
    if (clr) begin
      idx_n = '0;
    end else if (take) begin
      idx_n = last ? '0 : idx_q + IDX_W'(1);
      acc_n = value;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      acc_q <= '0;
    end else begin
      idx_q <= idx_n;
      acc_q <= acc_n;
    end
  end

endmodule

// File: rtl/dbg_seq_rep.sv
module dbg_seq_rep
  import dbg_seq_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [ITEM_W-1:0] val,
  input  logic              consume,
  output logic              ovf,
  output logic [CNT_W-1:0]  items
);

  // Largest item count the counter holds, widened to compare with val.
  localparam logic [ITEM_W:0] CNT_LIM = (ITEM_W+1)'({CNT_W{1'b1}});

  logic [ITEM_W-1:0] pend_q, pend_n;

  assign ovf   = {1'b0, val} >= CNT_LIM;
  assign items = CNT_W'(pend_q) + CNT_W'(1);

  always_comb begin
    pend_n = pend_q;
    if (clr || consume) begin
      pend_n = '0;
    end else if (load) begin
      pend_n = ovf ? ITEM_W'(CNT_LIM - 1'b1) : val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_n;
  end

endmodule

// File: rtl/dbg_insn_seq.sv
module dbg_insn_seq
  import dbg_seq_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              brk,
  output logic              op_vld,
  output logic [2:0]        op_code,
  output logic              item_vld,
  output logic [ITEM_W-1:0] item_data,
  output logic [WID_W-1:0]  item_bytes,
  output logic              item_dir,
  output logic              cmd_done,
  output logic              rep_vld,
  output logic [ITEM_W-1:0] rep_count,
  output logic              rep_ovf
);

  // Instruction state
  logic             busy_q, busy_n;
  logic             seg_q, seg_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  opc_e             opc_q, opc_n;
  dir_e             dir0_q, dir0_n, dir1_q, dir1_n;
  logic [WID_W-1:0] wid0_q, wid0_n, wid1_q, wid1_n;
  logic             seg2_q, seg2_n;

  // Output registers
  logic              op_vld_n, item_vld_n, cmd_done_n, rep_vld_n, rep_ovf_n;
  logic [2:0]        op_code_n;
  logic [ITEM_W-1:0] item_data_n, rep_count_n;
  logic [WID_W-1:0]  item_bytes_n;
  logic              item_dir_n;

  // Datapath links
  logic              accept, open_insn, take, item_end, seg_end, final_seg, insn_end;
  logic              rep_load, rep_consume, rep_ovf_c;
  logic [CNT_W-1:0]  rep_items, first_cnt;
  logic [WID_W-1:0]  cur_wid;
  dir_e              cur_dir;
  logic              asm_last;
  logic [ITEM_W-1:0] asm_value;
  sched_t            sch_d;

  dbg_seq_decode u_decode (
    .opc_bits (byte_data[7:5]),
    .arg_bits (byte_data[3:0]),
    .sched    (sch_d)
  );

  assign accept    = byte_vld && !brk;
  assign open_insn = accept && !busy_q;
  assign take      = accept && busy_q;
  assign cur_wid   = seg_q ? wid1_q : wid0_q;
  assign cur_dir   = seg_q ? dir1_q : dir0_q;
  assign item_end  = take && asm_last;
  assign seg_end   = item_end && (cnt_q == CNT_W'(1));
  assign final_seg = seg_q || !seg2_q;
  assign insn_end  = seg_end && final_seg;
  assign rep_load  = insn_end && (opc_q == OPC_REPEAT);
  assign rep_consume = open_insn && sch_d.rep_use;

  dbg_seq_asm u_asm (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (brk),
    .take  (take),
    .din   (byte_data),
    .wid   (cur_wid),
    .last  (asm_last),
    .value (asm_value)
  );

  dbg_seq_rep #(.CNT_W(CNT_W)) u_rep (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (brk),
    .load    (rep_load),
    .val     (asm_value),
    .consume (rep_consume),
    .ovf     (rep_ovf_c),
    .items   (rep_items)
  );

  always_comb begin
    if (sch_d.rep_use)      first_cnt = rep_items;
    else if (sch_d.key_run) first_cnt = CNT_W'(KEY_ITEMS);
    else                    first_cnt = CNT_W'(1);
  end

  // Sequencer next state
  always_comb begin
    busy_n = busy_q;
    seg_n  = seg_q;
    cnt_n  = cnt_q;
    opc_n  = opc_q;
    dir0_n = dir0_q;
    dir1_n = dir1_q;
    wid0_n = wid0_q;
    wid1_n = wid1_q;
    seg2_n = seg2_q;
    if (brk) begin
      busy_n = 1'b0;
      seg_n  = 1'b0;
    end else if (open_insn) begin
      busy_n = 1'b1;
      seg_n  = 1'b0;
      cnt_n  = first_cnt;
      opc_n  = sch_d.opc;
      dir0_n = sch_d.dir0;
      dir1_n = sch_d.dir1;
      wid0_n = sch_d.wid0;
      wid1_n = sch_d.wid1;
      seg2_n = sch_d.seg2;
    end else if (item_end) begin
      if (!seg_end) begin
        cnt_n = cnt_q - CNT_W'(1);
      end else if (final_seg) begin
        busy_n = 1'b0;
      end else begin
        seg_n = 1'b1;
        cnt_n = CNT_W'(1);
      end
    end
  end

  // Output next state
  always_comb begin
    op_vld_n     = open_insn;
    op_code_n    = open_insn ? byte_data[7:5] : op_code;
    item_vld_n   = item_end;
    item_data_n  = item_end ? asm_value : item_data;
    item_bytes_n = item_end ? cur_wid : item_bytes;
    item_dir_n   = item_end ? logic'(cur_dir) : item_dir;
    cmd_done_n   = insn_end;
    rep_vld_n    = rep_load;
    rep_count_n  = rep_load ? asm_value : rep_count;
    rep_ovf_n    = rep_load && rep_ovf_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      seg_q  <= 1'b0;
      cnt_q  <= '0;
      opc_q  <= OPC_LD_DIR;
      dir0_q <= DIR_H2D;
      dir1_q <= DIR_H2D;
      wid0_q <= '0;
      wid1_q <= '0;
      seg2_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      seg_q  <= seg_n;
      cnt_q  <= cnt_n;
      opc_q  <= opc_n;
      dir0_q <= dir0_n;
      dir1_q <= dir1_n;
      wid0_q <= wid0_n;
      wid1_q <= wid1_n;
      seg2_q <= seg2_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_vld     <= 1'b0;
      op_code    <= '0;
      item_vld   <= 1'b0;
      item_data  <= '0;
      item_bytes <= '0;
      item_dir   <= 1'b0;
      cmd_done   <= 1'b0;
      rep_vld    <= 1'b0;
      rep_count  <= '0;
      rep_ovf    <= 1'b0;
    end else begin
      op_vld     <= op_vld_n;
      op_code    <= op_code_n;
      item_vld   <= item_vld_n;
      item_data  <= item_data_n;
      item_bytes <= item_bytes_n;
      item_dir   <= item_dir_n;
      cmd_done   <= cmd_done_n;
      rep_vld    <= rep_vld_n;
      rep_count  <= rep_count_n;
      rep_ovf    <= rep_ovf_n;
    end
  end

endmodule

// File: rtl/dbg_insn_seq_chk.sv
module dbg_insn_seq_chk
  import dbg_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              byte_vld,
  input logic              brk,
  input logic              op_vld,
  input logic              item_vld,
  input logic [ITEM_W-1:0] item_data,
  input logic [WID_W-1:0]  item_bytes,
  input logic              cmd_done,
  input logic              rep_vld,
  input logic              rep_ovf
);

  p_op_from_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld |-> $past(byte_vld && !brk));

  p_op_not_item_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld |-> !item_vld);

  p_item_from_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    item_vld |-> $past(byte_vld && !brk));

  p_item_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    item_vld |-> (item_bytes >= WID_W'(1) && item_bytes <= WID_W'(ITEM_MAX_BYTES)));

  p_item_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    item_vld |-> ((item_data >> {item_bytes, 3'b000}) == '0));

  p_done_with_item_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> item_vld);

  p_rep_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rep_vld |-> cmd_done);

  p_ovf_with_rep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rep_ovf |-> rep_vld);

  p_break_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(brk) |-> (!op_vld && !item_vld && !cmd_done));

endmodule

bind dbg_insn_seq dbg_insn_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_vld   (byte_vld),
  .brk        (brk),
  .op_vld     (op_vld),
  .item_vld   (item_vld),
  .item_data  (item_data),
  .item_bytes (item_bytes),
  .cmd_done   (cmd_done),
  .rep_vld    (rep_vld),
  .rep_ovf    (rep_ovf)
);

// File: tb/dbg_insn_seq_bench.sv
module dbg_insn_seq_bench;

  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        byte_vld;
  logic [7:0]  byte_data;
  logic        brk;
  logic        op_vld;
  logic [2:0]  op_code;
  logic        item_vld;
  logic [31:0] item_data;
  logic [2:0]  item_bytes;
  logic        item_dir;
  logic        cmd_done;
  logic        rep_vld;
  logic [31:0] rep_count;
  logic        rep_ovf;

  int n_chk;
  int n_fail;

  dbg_insn_seq u_dbg_insn_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld   (byte_vld),
    .byte_data  (byte_data),
    .brk        (brk),
    .op_vld     (op_vld),
    .op_code    (op_code),
    .item_vld   (item_vld),
    .item_data  (item_data),
    .item_bytes (item_bytes),
    .item_dir   (item_dir),
    .cmd_done   (cmd_done),
    .rep_vld    (rep_vld),
    .rep_count  (rep_count),
    .rep_ovf    (rep_ovf)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Present one byte; returns at the falling edge after the accepting edge.
  task automatic send(input logic [7:0] b);
    @(negedge clk);
    byte_vld  = 1'b1;
    byte_data = b;
    @(negedge clk);
    byte_vld  = 1'b0;
  endtask

  task automatic send_brk(input logic with_byte, input logic [7:0] b);
    @(negedge clk);
    brk       = 1'b1;
    byte_vld  = with_byte;
    byte_data = b;
    @(negedge clk);
    brk       = 1'b0;
    byte_vld  = 1'b0;
  endtask

  task automatic exp_op(input string req, input logic [2:0] opc);
    chk(req, op_vld, 1'b1);
    chk(req, op_code, opc);
    chk(req, item_vld, 1'b0);
  endtask

  task automatic exp_quiet(input string req);
    chk(req, item_vld, 1'b0);
    chk(req, cmd_done, 1'b0);
  endtask

  task automatic exp_item(input string req, input logic [31:0] d, input logic [2:0] nb,
                          input logic dir, input logic done);
    chk(req, item_vld, 1'b1);
    chk(req, item_data, d);
    chk(req, item_bytes, nb);
    chk(req, item_dir, dir);
    chk({req, " R11 end"}, cmd_done, done);
  endtask

  task automatic t_reset;
    chk("R13 op_vld", op_vld, 1'b0);
    chk("R13 item_vld", item_vld, 1'b0);
    chk("R13 cmd_done", cmd_done, 1'b0);
    chk("R13 rep_vld", rep_vld, 1'b0);
    chk("R13 rep_ovf", rep_ovf, 1'b0);
    chk("R13 rep_count", rep_count, 32'h0);
  endtask

  task automatic t_load_direct;
    send(8'h06); exp_op("R1 load-direct", 3'd0);
    send(8'h34); exp_quiet("R4 partial address");
    send(8'h12); exp_item("R2 address", 32'h0000_1234, 3'd2, 1'b0, 1'b0);
    send(8'hAA); exp_quiet("R4 partial data");
    send(8'hBB); exp_quiet("R4 partial data");
    send(8'hCC); exp_item("R2 R4 read data", 32'h00CC_BBAA, 3'd3, 1'b1, 1'b1);
  endtask

  task automatic t_store_direct;
    send(8'h4F); exp_op("R1 store-direct", 3'd2);
    send(8'h78); send(8'h56); send(8'h34);
    exp_quiet("R3 partial address");
    send(8'h12); exp_item("R3 address", 32'h1234_5678, 3'd4, 1'b0, 1'b0);
    send(8'hEF); send(8'hBE); send(8'hAD);
    send(8'hDE); exp_item("R3 data", 32'hDEAD_BEEF, 3'd4, 1'b0, 1'b1);
  endtask

  task automatic t_ctrl;
    send(8'h8F); exp_op("R1 load-control", 3'd4);
    send(8'h5A); exp_item("R5 load-control", 32'h5A, 3'd1, 1'b1, 1'b1);
    send(8'hC2); exp_op("R1 store-control", 3'd6);
    send(8'h01); exp_item("R5 store-control", 32'h01, 3'd1, 1'b0, 1'b1);
  endtask

  task automatic t_key;
    send(8'hE0); exp_op("R1 key", 3'd7);
    for (int i = 0; i < 8; i++) begin
      send(8'h10 + 8'(i));
      exp_item("R6 key byte", 32'h10 + 32'(i), 3'd1, 1'b0, i == 7);
    end
  endtask

  task automatic t_repeat;
    send(8'hA1); exp_op("R1 repeat", 3'd5);
    send(8'h03); exp_quiet("R7 partial count");
    send(8'h00); exp_item("R7 count item", 32'h3, 3'd2, 1'b0, 1'b1);
    chk("R7 rep_vld", rep_vld, 1'b1);
    chk("R7 rep_count", rep_count, 32'h3);
    chk("R12 no overflow", rep_ovf, 1'b0);
    send(8'h60); exp_op("R8 store-pointer", 3'd3);
    for (int i = 0; i < 4; i++) begin
      send(8'hC0 + 8'(i));
      exp_item("R8 repeated store", 32'hC0 + 32'(i), 3'd1, 1'b0, i == 3);
    end
    send(8'h6D); exp_op("R8 store-pointer reserved mode", 3'd3);
    send(8'h11); exp_quiet("R8 partial");
    send(8'h22); exp_item("R8 count consumed", 32'h2211, 3'd2, 1'b0, 1'b1);
  endtask

  task automatic t_hold;
    send(8'hA0); send(8'h02);
    chk("R7 rep_count 2", rep_count, 32'h2);
    send(8'h80); send(8'h77); exp_item("R9 control between", 32'h77, 3'd1, 1'b1, 1'b1);
    send(8'h40); send(8'h10); exp_item("R9 direct addr", 32'h10, 3'd1, 1'b0, 1'b0);
    send(8'h20); exp_item("R9 direct data", 32'h20, 3'd1, 1'b0, 1'b1);
    send(8'h21); exp_op("R9 load-pointer", 3'd1);
    for (int i = 0; i < 3; i++) begin
      send(8'h01 + 8'(i));
      exp_quiet("R9 partial");
      send(8'hA0);
      exp_item("R9 held count", 32'hA001 + 32'(i), 3'd2, 1'b1, i == 2);
    end
  endtask

  task automatic t_break;
    send(8'h4F); send(8'h01); send(8'h02);
    send_brk(1'b0, 8'h00);
    chk("R10 break quiet", op_vld, 1'b0);
    exp_quiet("R10 break quiet");
    send(8'h8F); exp_op("R10 opcode after break", 3'd4);
    send(8'h00); exp_item("R10 finish", 32'h0, 3'd1, 1'b1, 1'b1);
    send(8'hA0); send(8'h05);
    chk("R7 rep_count 5", rep_count, 32'h5);
    send_brk(1'b0, 8'h00);
    send(8'h30); exp_op("R10 load-pointer", 3'd1);
    send(8'h99); exp_item("R10 count cleared", 32'h99, 3'd1, 1'b1, 1'b1);
    send_brk(1'b1, 8'h20);
    chk("R10 byte with break ignored", op_vld, 1'b0);
    chk("R10 byte with break ignored", item_vld, 1'b0);
    send(8'hC0); exp_op("R10 opcode after break byte", 3'd6);
    send(8'h00); exp_item("R10 finish", 32'h0, 3'd1, 1'b0, 1'b1);
  endtask

  task automatic t_ovf;
    send(8'hA3);
    send(8'hFF); send(8'hFF); send(8'hFF); send(8'hFF);
    chk("R12 rep_vld", rep_vld, 1'b1);
    chk("R12 count", rep_count, 32'hFFFF_FFFF);
    chk("R12 overflow", rep_ovf, 1'b1);
    send_brk(1'b0, 8'h00);
    send(8'hA3);
    send(8'hFE); send(8'hFF); send(8'hFF); send(8'hFF);
    chk("R12 count edge", rep_count, 32'hFFFF_FFFE);
    chk("R12 edge no overflow", rep_ovf, 1'b0);
    send_brk(1'b0, 8'h00);
  endtask

  initial begin
    n_chk     = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    byte_vld  = 1'b0;
    byte_data = 8'h00;
    brk       = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_load_direct;
    t_store_direct;
    t_ctrl;
    t_key;
    t_repeat;
    t_hold;
    t_break;
    t_ovf;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule